// File: doc/BRIEF.md
# Signed Multiply-Accumulate Engine with Split Accumulator

This block multiplies pairs of signed 16-bit words and sums the products into a 42-bit accumulator. Software sees the accumulator as two pieces: a 32-bit low piece and a 10-bit high piece. A command port issues one operation at a time. The operations are: zero the accumulator, load a piece from a 32-bit data word, read a piece out onto a 32-bit result port while updating condition flags, and accumulate.

For an accumulate, the block fetches both operands through a single-word memory read port. The two operand addresses come in as pointer values, and the advanced pointers come back on output ports. When both operands are addressed through the same pointer, the second fetch reads the word that follows the first one, and the pointer advances twice. The block holds a sticky overflow record. The record is set when a sum leaves the signed 42-bit range, and it is cleared by a clear command or by either load.

Top module: `mac_split_acc`

## Requirements
- R1: Opcode 0 (clear) sets the whole accumulator to zero and clears the overflow record. It changes none of the N, Z, V and C flags.
- R2: Opcode 5 (accumulate) adds the signed 16x16 product of the two fetched words to the accumulator, which wraps modulo 2^42. Example: -2 times 2 from zero gives 0xFFFFFFFC in the low piece and 0xFFFFFFFF when the high piece is read.
- R3: Opcode 4 (read high) puts bits 41..32 of the accumulator on `result`, sign-extended from bit 41 to 32 bits. Loading 0xA5A5A5A5 into the high piece reads back as 0x000001A5.
- R4: Opcode 1 (load low) writes all 32 data bits into accumulator bits 31..0. Opcode 2 (load high) writes data bits 9..0 into accumulator bits 41..32. Both loads clear V and C and keep N and Z.
- R5: Opcodes 3 (read low) and 4 (read high) set Z when the full 42-bit accumulator is zero and set N from bit 41. So the high piece of a small positive value reads 0 with Z clear.
- R6: On either read, V shows whether any accumulate since the last clear or load overflowed the signed 42-bit range.
- R7: An accumulate with `same_ptr` low fetches the first word at `ptr_a_in` and the second word at `ptr_b_in`, using byte addresses and one request per word. The outputs return each pointer advanced by 2.
- R8: With `same_ptr` high, the accumulate fetches at `ptr_a_in` and then at `ptr_a_in`+2. Both pointer outputs return `ptr_a_in`+4. Eight such accumulates of 0x7FFF squared give 0x00000001 high and 0xFFF80008 low.
- R9: An accumulate leaves all flags unchanged. Its `done` pulse comes one cycle after the sum is registered. Every other valid opcode pulses `done` in the cycle after it is accepted.
- R10: A command presented while `busy` is high is ignored. Opcodes 6 and 7 change nothing and give no `done`.
- R11: After reset, the accumulator, the overflow record, all flags, `result`, `done`, `busy` and `mem_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode (see requirements) |
| cmd_data | input | 32 | Load data |
| ptr_a_in | input | 32 | First operand pointer |
| ptr_b_in | input | 32 | Second operand pointer |
| same_ptr | input | 1 | Both operands use the first pointer |
| busy | output | 1 | Accumulate in progress; commands ignored |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Value of the piece read |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| ptr_a_out | output | 32 | Advanced first pointer |
| ptr_b_out | output | 32 | Advanced second pointer |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |

## Verification
The assertions check several properties on every cycle:
- clear and load reach the accumulator at the next edge;
- the overflow record stays set until a clear or a load;
- flags move only on reads and loads;
- Z and the high-piece sign extension follow the accumulator that was read;
- requests last one cycle;
- pointer outputs advance by the right step.

Only the bench scenarios can show that the product values and carries into the high piece are correct, and that the chained same-pointer fetches read the right words. They also show that commands issued while busy or with unused opcodes leave no trace, and that a signed overflow is reported in V on a later read.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    OP_CLEAR    = 3'd0,
    OP_LOAD_LO  = 3'd1,
    OP_LOAD_HI  = 3'd2,
    OP_STORE_LO = 3'd3,
    OP_STORE_HI = 3'd4,
    OP_ACCUM    = 3'd5
  } mac_op_e;
endpackage

// File: rtl/mac_fetch_ctrl.sv
module mac_fetch_ctrl #(
  parameter int AW  = 32,
  parameter int OPW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [AW-1:0]  ptr_a,
  input  logic [AW-1:0]  ptr_b,
  input  logic           same_ptr,
  input  logic           mem_rvalid,
  input  logic [OPW-1:0] mem_rdata,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  output logic [OPW-1:0] op_a,
  output logic [OPW-1:0] op_b,
  output logic           ops_valid,
  output logic           busy,
  output logic [AW-1:0]  ptr_a_upd,
  output logic [AW-1:0]  ptr_b_upd
);
  localparam logic [AW-1:0] STEP  = AW'(OPW / 8);
  localparam logic [AW-1:0] STEP2 = AW'(2 * (OPW / 8));

  typedef enum logic [1:0] {S_IDLE, S_WAIT_A, S_WAIT_B, S_ADD} fsm_e;
  fsm_e state;
  logic [AW-1:0] second_addr;

  assign busy      = (state != S_IDLE);
  assign ops_valid = (state == S_ADD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      second_addr <= '0;
      op_a        <= '0;
      op_b        <= '0;
      ptr_a_upd   <= '0;
      ptr_b_upd   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          mem_req     <= 1'b1;
          mem_addr    <= ptr_a;
          second_addr <= same_ptr ? ptr_a + STEP : ptr_b;
          ptr_a_upd   <= same_ptr ? ptr_a + STEP2 : ptr_a + STEP;
          ptr_b_upd   <= same_ptr ? ptr_a + STEP2 : ptr_b + STEP;
          state       <= S_WAIT_A;
        end
        S_WAIT_A: begin
          mem_req <= 1'b0;
          if (mem_rvalid) begin
            op_a     <= mem_rdata;
            mem_req  <= 1'b1;
            mem_addr <= second_addr;
            state    <= S_WAIT_B;
          end
        end
        S_WAIT_B: begin
          mem_req <= 1'b0;
          if (mem_rvalid) begin
            op_b  <= mem_rdata;
            state <= S_ADD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: each request lasts a single cycle
  a_r7_single_req: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  // R7: separate pointers each advance by one word
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !same_ptr) |=>
      (ptr_a_upd == $past(ptr_a) + STEP) && (ptr_b_upd == $past(ptr_b) + STEP));
  // R8: a shared pointer advances by two words
  a_r8_same_step: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && same_ptr) |=> (ptr_a_upd == $past(ptr_a) + STEP2));
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int OPW  = 16,
  parameter int ACCW = 42,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [DW-1:0]   ld_data,
  input  logic            add_en,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  output logic [ACCW-1:0] acc,
  output logic            ovf
);
  localparam int HIW  = ACCW - DW;
  localparam int PW   = 2 * OPW;
  localparam int TOP  = ACCW - 1;

  logic signed [PW-1:0] prod;
  logic [ACCW-1:0] prod_ext, sum;
  logic add_ovf;

  assign prod     = $signed(op_a) * $signed(op_b);
  assign prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};
  assign sum      = acc + prod_ext;
  assign add_ovf  = (acc[TOP] == prod_ext[TOP]) && (sum[TOP] != acc[TOP]);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (ld_lo) begin
      acc[DW-1:0] <= ld_data;
      ovf         <= 1'b0;
    end else if (ld_hi) begin
      acc[ACCW-1:DW] <= ld_data[HIW-1:0];
      ovf            <= 1'b0;
    end else if (add_en) begin
      acc <= sum;
      ovf <= ovf | add_ovf;
    end
  end

  // R1: clear empties accumulator and overflow record
  a_r1_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0) && !ovf);
  // R4: low load takes all data bits and keeps the high piece
  a_r4_load_lo: assert property (@(posedge clk) disable iff (rst)
    (ld_lo && !clr) |=> (acc[DW-1:0] == $past(ld_data)) &&
                        (acc[ACCW-1:DW] == $past(acc[ACCW-1:DW])));
  // R6: overflow record persists until clear or load
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr && !ld_lo && !ld_hi) |=> ovf);
  // R2: accumulator holds without a command
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !(clr || ld_lo || ld_hi || add_en) |=> $stable(acc));
endmodule

// File: rtl/mac_flags.sv
module mac_flags #(
  parameter int ACCW = 42,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_lo,
  input  logic            st_hi,
  input  logic            ld_any,
  input  logic [ACCW-1:0] acc,
  input  logic            ovf,
  output logic [DW-1:0]   result,
  output logic            fn,
  output logic            fz,
  output logic            fv,
  output logic            fc
);
  localparam int HIW = ACCW - DW;

  logic [DW-1:0] hi_ext;
  assign hi_ext = {{(DW-HIW){acc[ACCW-1]}}, acc[ACCW-1:DW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      fn <= 1'b0; fz <= 1'b0; fv <= 1'b0; fc <= 1'b0;
    end else if (st_lo || st_hi) begin
      result <= st_hi ? hi_ext : acc[DW-1:0];
      fn     <= acc[ACCW-1];
      fz     <= (acc == '0);
      fv     <= ovf;
    end else if (ld_any) begin
      fv <= 1'b0;
      fc <= 1'b0;
    end
  end

  // R5: Z follows the full accumulator
  a_r5_zero: assert property (@(posedge clk) disable iff (rst)
    (st_lo || st_hi) |=> (fz == ($past(acc) == '0)));
  // R9: flags move only on reads and loads
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !(st_lo || st_hi || ld_any) |=> $stable({fn, fz, fv, fc}));
  // R3: high read is sign-extended from the accumulator top bit
  a_r3_hi_sign: assert property (@(posedge clk) disable iff (rst)
    st_hi |=> ($past(acc[ACCW-1]) ? (&result[DW-1:HIW-1]) : !(|result[DW-1:HIW-1])));
endmodule

// File: rtl/mac_split_acc.sv
module mac_split_acc #(
  parameter int OPW  = 16,
  parameter int ACCW = 42,
  parameter int DW   = 32,
  parameter int AW   = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_op,
  input  logic [DW-1:0]  cmd_data,
  input  logic [AW-1:0]  ptr_a_in,
  input  logic [AW-1:0]  ptr_b_in,
  input  logic           same_ptr,
  output logic           busy,
  output logic           done,
  output logic [DW-1:0]  result,
  output logic           flag_n,
  output logic           flag_z,
  output logic           flag_v,
  output logic           flag_c,
  output logic [AW-1:0]  ptr_a_out,
  output logic [AW-1:0]  ptr_b_out,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_rvalid,
  input  logic [OPW-1:0] mem_rdata
);
  import mac_pkg::*;

  logic accept, do_clr, do_ld_lo, do_ld_hi, do_st_lo, do_st_hi, do_acc;
  logic ops_valid, ovf;
  logic [OPW-1:0]  op_a, op_b;
  logic [ACCW-1:0] acc;

  assign accept   = cmd_valid && !busy;
  assign do_clr   = accept && (cmd_op == OP_CLEAR);
  assign do_ld_lo = accept && (cmd_op == OP_LOAD_LO);
  assign do_ld_hi = accept && (cmd_op == OP_LOAD_HI);
  assign do_st_lo = accept && (cmd_op == OP_STORE_LO);
  assign do_st_hi = accept && (cmd_op == OP_STORE_HI);
  assign do_acc   = accept && (cmd_op == OP_ACCUM);

  mac_fetch_ctrl #(.AW(AW), .OPW(OPW)) fetch_i (
    .clk(clk), .rst(rst), .start(do_acc),
    .ptr_a(ptr_a_in), .ptr_b(ptr_b_in), .same_ptr(same_ptr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .op_a(op_a), .op_b(op_b), .ops_valid(ops_valid), .busy(busy),
    .ptr_a_upd(ptr_a_out), .ptr_b_upd(ptr_b_out)
  );

  mac_accum #(.OPW(OPW), .ACCW(ACCW), .DW(DW)) accum_i (
    .clk(clk), .rst(rst), .clr(do_clr), .ld_lo(do_ld_lo), .ld_hi(do_ld_hi),
    .ld_data(cmd_data), .add_en(ops_valid), .op_a(op_a), .op_b(op_b),
    .acc(acc), .ovf(ovf)
  );

  mac_flags #(.ACCW(ACCW), .DW(DW)) flags_i (
    .clk(clk), .rst(rst), .st_lo(do_st_lo), .st_hi(do_st_hi),
    .ld_any(do_ld_lo || do_ld_hi), .acc(acc), .ovf(ovf),
    .result(result), .fn(flag_n), .fz(flag_z), .fv(flag_v), .fc(flag_c)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= ops_valid || do_clr || do_ld_lo || do_ld_hi || do_st_lo || do_st_hi;
  end

  // R9: done follows the registered sum of an accumulate
  a_r9_done_after_add: assert property (@(posedge clk) disable iff (rst)
    ops_valid |=> done);
  // R10: unused opcodes give no completion
  a_r10_bad_op: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && (cmd_op > 3'd5) && !ops_valid) |=> !done);
endmodule

// File: tb/mac_split_acc_tb_top.sv
module mac_split_acc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PA = 32'h10, PB = 32'h30;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] data;
    logic [15:0] wa;
    logic [15:0] wb;
    logic [31:0] exp;
    logic        en;
    logic        ez;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0, 16'h0, 16'h0, 32'h0, 1'b0, 1'b0},
    '{3'd5, 32'h0, 16'h0002, 16'h0002, 32'h0, 1'b0, 1'b0},
    '{3'd3, 32'h0, 16'h0, 16'h0, 32'h4, 1'b0, 1'b0},
    '{3'd4, 32'h0, 16'h0, 16'h0, 32'h0, 1'b0, 1'b0},
    '{3'd0, 32'h0, 16'h0, 16'h0, 32'h0, 1'b0, 1'b0},
    '{3'd5, 32'h0, 16'hFFFE, 16'h0002, 32'h0, 1'b0, 1'b0},
    '{3'd3, 32'h0, 16'h0, 16'h0, 32'hFFFFFFFC, 1'b1, 1'b0},
    '{3'd4, 32'h0, 16'h0, 16'h0, 32'hFFFFFFFF, 1'b1, 1'b0},
    '{3'd2, 32'hA5A5A5A5, 16'h0, 16'h0, 32'h0, 1'b0, 1'b0},
    '{3'd4, 32'h0, 16'h0, 16'h0, 32'h000001A5, 1'b0, 1'b0},
    '{3'd1, 32'h12345678, 16'h0, 16'h0, 32'h0, 1'b0, 1'b0},
    '{3'd3, 32'h0, 16'h0, 16'h0, 32'h12345678, 1'b0, 1'b0},
    '{3'd0, 32'h0, 16'h0, 16'h0, 32'h0, 1'b0, 1'b0},
    '{3'd5, 32'h0, 16'h0000, 16'h0000, 32'h0, 1'b0, 1'b0},
    '{3'd3, 32'h0, 16'h0, 16'h0, 32'h0, 1'b0, 1'b1},
    '{3'd4, 32'h0, 16'h0, 16'h0, 32'h0, 1'b0, 1'b1}
  };

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, same_ptr = 0;
  logic [2:0] cmd_op = 0;
  logic [31:0] cmd_data = 0, ptr_a_in = 0, ptr_b_in = 0;
  logic busy, done, flag_n, flag_z, flag_v, flag_c, mem_req;
  logic [31:0] result, ptr_a_out, ptr_b_out, mem_addr;
  logic mem_rvalid = 0;
  logic [15:0] mem_rdata = 0;
  logic [15:0] mem [64];
  logic [31:0] addr_log [256];
  int nlog = 0;
  int checks = 0, failures = 0, cycles = 0;
  logic finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_split_acc dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .ptr_a_in(ptr_a_in), .ptr_b_in(ptr_b_in),
    .same_ptr(same_ptr), .busy(busy), .done(done), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .ptr_a_out(ptr_a_out), .ptr_b_out(ptr_b_out), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem[mem_addr[6:1]];
    if (mem_req) begin
      addr_log[nlog[7:0]] <= mem_addr;
      nlog <= nlog + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(logic [2:0] op, logic [31:0] data,
                         logic [31:0] pa, logic [31:0] pb, logic same);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_data = data;
    ptr_a_in = pa; ptr_b_in = pb; same_ptr = same;
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        finish_run();
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 done", {31'b0, done}, 0);
    chk("R11 busy", {31'b0, busy}, 0);
    chk("R11 mem_req", {31'b0, mem_req}, 0);
    chk("R11 flags", {28'b0, flag_n, flag_z, flag_v, flag_c}, 0);
    chk("R11 result", result, 0);
    run_cmd(3'd3, 0, 0, 0, 0);
    chk("R11 R5 store after reset", result, 0);
    chk("R11 R5 zero flag", {31'b0, flag_z}, 1);

    // Vector table: R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].op == 3'd5) begin
        int n0;
        mem[PA[6:1]] = VECS[v].wa;
        mem[PB[6:1]] = VECS[v].wb;
        n0 = nlog;
        run_cmd(3'd5, 0, PA, PB, 0);
        chk("R7 ptr_a_out", ptr_a_out, PA + 2);
        chk("R7 ptr_b_out", ptr_b_out, PB + 2);
        chk("R7 first addr", addr_log[n0[7:0]], PA);
        chk("R7 second addr", addr_log[8'(n0 + 1)], PB);
      end else begin
        run_cmd(VECS[v].op, VECS[v].data, 0, 0, 0);
        if (VECS[v].op == 3'd3 || VECS[v].op == 3'd4) begin
          chk("R2 R3 R4 table result", result, VECS[v].exp);
          chk("R5 table N", {31'b0, flag_n}, {31'b0, VECS[v].en});
          chk("R5 table Z", {31'b0, flag_z}, {31'b0, VECS[v].ez});
        end
      end
    end

    // R8 same pointer, 2 x 4
    begin
      int n0;
      mem[6'h20] = 16'd2; mem[6'h21] = 16'd4;
      run_cmd(3'd0, 0, 0, 0, 0);
      n0 = nlog;
      run_cmd(3'd5, 0, 32'h40, 32'h0, 1);
      chk("R8 addr first", addr_log[n0[7:0]], 32'h40);
      chk("R8 addr second", addr_log[8'(n0 + 1)], 32'h42);
      chk("R8 ptr_a_out", ptr_a_out, 32'h44);
      run_cmd(3'd3, 0, 0, 0, 0);
      chk("R8 product", result, 32'd8);
    end

    // R9 / R1 flags untouched by accumulate and clear
    mem[6'h20] = 16'hFFFE; mem[6'h21] = 16'd2;
    run_cmd(3'd0, 0, 0, 0, 0);
    run_cmd(3'd5, 0, 32'h40, 0, 1);
    run_cmd(3'd3, 0, 0, 0, 0);
    chk("R9 setup N", {31'b0, flag_n}, 1);
    mem[6'h20] = 16'd1; mem[6'h21] = 16'd1;
    run_cmd(3'd5, 0, 32'h40, 0, 1);
    chk("R9 flags after accumulate", {28'b0, flag_n, flag_z, flag_v, flag_c}, 32'h8);
    run_cmd(3'd0, 0, 0, 0, 0);
    chk("R1 flags after clear", {28'b0, flag_n, flag_z, flag_v, flag_c}, 32'h8);
    run_cmd(3'd4, 0, 0, 0, 0);
    chk("R1 cleared high", result, 0);
    chk("R1 cleared Z", {31'b0, flag_z}, 1);

    // R8 chained eight squares of 0x7FFF
    begin
      logic [31:0] p;
      for (int i = 0; i < 16; i++) mem[6'h30 + i] = 16'h7FFF;
      run_cmd(3'd0, 0, 0, 0, 0);
      p = 32'h60;
      for (int k = 0; k < 8; k++) begin
        run_cmd(3'd5, 0, p, 0, 1);
        p = ptr_a_out;
      end
      chk("R8 chained pointer", p, 32'h80);
      run_cmd(3'd4, 0, 0, 0, 0);
      chk("R8 R2 carry into high", result, 32'h1);
      chk("R6 no overflow", {31'b0, flag_v}, 0);
      run_cmd(3'd3, 0, 0, 0, 0);
      chk("R8 R2 low", result, 32'hFFF80008);
    end

    // R6 / R4 overflow and its clearing by load
    run_cmd(3'd2, 32'h000001FF, 0, 0, 0);
    run_cmd(3'd1, 32'hFFFFFFFF, 0, 0, 0);
    chk("R4 V C after load", {30'b0, flag_v, flag_c}, 0);
    mem[6'h20] = 16'd1; mem[6'h21] = 16'd1;
    run_cmd(3'd5, 0, 32'h40, 0, 1);
    run_cmd(3'd4, 0, 0, 0, 0);
    chk("R2 wrap high", result, 32'hFFFFFE00);
    chk("R6 V set", {31'b0, flag_v}, 1);
    chk("R5 N on wrap", {31'b0, flag_n}, 1);
    run_cmd(3'd1, 32'd5, 0, 0, 0);
    chk("R4 load clears V", {31'b0, flag_v}, 0);
    run_cmd(3'd3, 0, 0, 0, 0);
    chk("R6 V after load", {31'b0, flag_v}, 0);
    chk("R4 low load value", result, 32'd5);

    // R10 command during busy is ignored
    mem[6'h20] = 16'd3; mem[6'h21] = 16'd3;
    run_cmd(3'd0, 0, 0, 0, 0);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd5; ptr_a_in = 32'h40; same_ptr = 1;
    @(negedge clk);
    cmd_op = 3'd0;
    @(negedge clk);
    cmd_valid = 0;
    while (!done) @(negedge clk);
    run_cmd(3'd3, 0, 0, 0, 0);
    chk("R10 clear during busy ignored", result, 32'd9);

    // R10 unused opcode
    begin
      logic saw;
      saw = 0;
      @(negedge clk);
      cmd_valid = 1; cmd_op = 3'd6; cmd_data = 32'hFFFFFFFF;
      @(negedge clk);
      cmd_valid = 0;
      for (int i = 0; i < 3; i++) begin
        if (done) saw = 1;
        @(negedge clk);
      end
      chk("R10 no done for opcode 6", {31'b0, saw}, 0);
      run_cmd(3'd3, 0, 0, 0, 0);
      chk("R10 opcode 6 no effect", result, 32'd9);
    end

    finished = 1;
    finish_run();
  end
endmodule